// File: doc/BRIEF.md
# Serial Synthesizer Programming Register

This block takes configuration words for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. All three lines are sampled by the system clock. Each rising edge of the serial clock shifts one data bit into a 24-bit word, most significant bit first. A rising edge of the load strobe then commits the word. The two lowest bits of the word choose one of four destination latches. The payload of the word becomes parallel control fields.

There are four destinations. The reference latch holds the reference divide value, the anti-backlash width code and the lock-detect precision bit. The divider latch holds the A count, the B count and the gain bit. The function latch holds the prescaler code, the power-down bits, the charge-pump current codes, the fastlock controls, the timer code, the output mux code, the detector polarity, the charge-pump three-state bit and the counter-reset bit. The initialization latch writes the same fields as the function latch and also raises a one-cycle pulse so that the divider counters restart.

Some loads are refused. A load that arrives before a full word has been shifted is refused, and so is a reference word with illegal contents. A refused load leaves every latch unchanged and raises a one-cycle error pulse.

A small receive state machine tracks progress through the word:
- `ST_EMPTY` means no bits have arrived since reset or since the last load.
- `ST_FILL` means between 1 and 23 bits have arrived.
- `ST_FULL` means at least 24 bits have arrived.

The transitions are:
- `EMPTY->FILL` on the first shifted bit.
- `FILL->FULL` on the 24th shifted bit.
- `FULL->FULL` on any further bits.
- `any->EMPTY` on a load strobe edge, whether or not the load was accepted.

Top module: `synth_prog_reg`

## Requirements
- R1: After reset every field output, `init_pulse` and `load_err` are 0.
- R2: Bits are shifted on rising edges of `ser_clk`, most significant first, so the first bit sent ends up as word bit 23.
- R3: A rising edge of `ser_le` in state ST_FULL routes the word by bits 1:0 (00 reference, 01 divider, 10 function, 11 initialization). The fields are visible one system clock after the edge is sampled.
- R4: Reference word fields: bits 15:2 go to `ref_div`, bits 17:16 to `backlash_sel`, and bit 20 to `lock_prec`.
- R5: A reference word whose bits 15:2 are zero, or whose bits 19:18 are not 00, is refused. `load_err` pulses and `ref_div` never changes to 0.
- R6: Divider word fields: bits 7:2 go to `a_cnt`, bits 20:8 to `b_cnt`, and bit 21 to `cp_gain`.
- R7: Function word fields, from the top bit down:
  - bits 23:22 `prescale_sel`
  - bit 21 `pd2`
  - bits 20:18 `cur2`
  - bits 17:15 `cur1`
  - bits 14:11 `timer_sel`
  - bit 10 `fl_mode`
  - bit 9 `fl_en`
  - bit 8 `cp_tristate`
  - bit 7 `pd_pol`
  - bits 6:4 `mux_sel`
  - bit 3 `pd1`
  - bit 2 `cnt_hold`
- R8: An initialization word loads the same fields as R7 and raises `init_pulse` for exactly one cycle. A function word never raises `init_pulse`.
- R9: A load with fewer than 24 serial clock edges since the previous load or reset raises `load_err` for one cycle and changes no output field. The bit count restarts after every load.
- R10: When more than 24 bits precede a load, only the last 24 bits shifted form the word.
- R11: An accepted load changes only the fields of the latch it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, commits on rising edge |
| ref_div | output | 14 | Reference divide value |
| backlash_sel | output | 2 | Anti-backlash width code |
| lock_prec | output | 1 | Lock-detect precision |
| a_cnt | output | 6 | A count |
| b_cnt | output | 13 | B count |
| cp_gain | output | 1 | Gain bit |
| prescale_sel | output | 2 | Prescaler code |
| pd2 | output | 1 | Power-down bit 2 |
| cur2 | output | 3 | Current setting 2 |
| cur1 | output | 3 | Current setting 1 |
| timer_sel | output | 4 | Timer code |
| fl_mode | output | 1 | Fastlock mode |
| fl_en | output | 1 | Fastlock enable |
| cp_tristate | output | 1 | Charge-pump three-state |
| pd_pol | output | 1 | Phase detector polarity |
| mux_sel | output | 3 | Output mux code |
| pd1 | output | 1 | Power-down bit 1 |
| cnt_hold | output | 1 | Counter-reset control bit |
| init_pulse | output | 1 | One-cycle pulse on initialization load |
| load_err | output | 1 | One-cycle pulse on refused load |

## Verification
The bench builds the block with its default parameters. These are a 14-bit reference value, a 6-bit A count, a 13-bit B count and reference checking switched on (`CHECK_REF=1`), which gives the 24-bit word.

With these values the bench can reach:
- the largest A, B and reference values;
- the illegal reference cases: a zero divide value and nonzero test bits;
- the short-load and over-long-load boundaries around exactly 24 shifted bits.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        SEL_REF  = 2'b00,
        SEL_DIV  = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } rx_state_e;

    // Function/initialization payload, packed top bit first (word bits 23:2).
    typedef struct packed {
        logic [1:0] prescale;
        logic       pd2;
        logic [2:0] cur2;
        logic [2:0] cur1;
        logic [3:0] timer;
        logic       fl_mode;
        logic       fl_en;
        logic       cp_tri;
        logic       pd_pol;
        logic [2:0] mux;
        logic       pd1;
        logic       cnt_hold;
    } func_t;

    localparam int FUNC_W = $bits(func_t);
endpackage

// File: rtl/sprog_rx.sv
module sprog_rx #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic              shift_en,
    output logic              le_rise,
    output logic [WORD_W-1:0] word
);
    logic sclk_q;
    logic le_q;

    // Edge detection on the sampled serial lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
            le_q   <= ser_le;
        end
    end

    // A load edge takes priority over a shift edge in the same cycle.
    assign le_rise  = ser_le & ~le_q;
    assign shift_en = ser_clk & ~sclk_q & ~le_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WORD_W-2:0], ser_data};
        end
    end

    // R2: a shift must move the previous word up by one bit
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0]));
endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
    import sprog_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              le_rise,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ref_ok,
    output logic              wr_ref,
    output logic              wr_div,
    output logic              wr_func,
    output logic              wr_init,
    output logic              load_err
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    rx_state_e        state, nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic             accept;
    latch_sel_e       sel;

    assign sel = latch_sel_e'(addr);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    // Bit counter: saturates at a full word, restarts on every load.
    always_ff @(posedge clk) begin
        if (!rst_n)                             bit_cnt <= '0;
        else if (le_rise)                       bit_cnt <= '0;
        else if (shift_en && bit_cnt != CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (le_rise)       nxt = ST_EMPTY;
                else if (shift_en) nxt = (WORD_W == 1) ? ST_FULL : ST_FILL;
            end
            ST_FILL: begin
                if (le_rise)                               nxt = ST_EMPTY;
                else if (shift_en && bit_cnt == CNT_LAST)  nxt = ST_FULL;
            end
            ST_FULL: begin
                if (le_rise) nxt = ST_EMPTY;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    // Output decode: write strobes for the addressed latch.
    always_comb begin
        accept  = le_rise && (state == ST_FULL) && ((sel != SEL_REF) || ref_ok);
        wr_ref  = 1'b0;
        wr_div  = 1'b0;
        wr_func = 1'b0;
        wr_init = 1'b0;
        if (accept) begin
            unique case (sel)
                SEL_REF:  wr_ref  = 1'b1;
                SEL_DIV:  wr_div  = 1'b1;
                SEL_FUNC: wr_func = 1'b1;
                SEL_INIT: wr_init = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) load_err <= 1'b0;
        else        load_err <= le_rise && !accept;
    end

    // R9: a load before a full word must be flagged next cycle
    assert_short_load_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && state != ST_FULL) |=> load_err);

    // R10: the full state always agrees with a saturated bit count
    assert_full_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (bit_cnt == CNT_FULL));

    // R11: at most one latch is written per load
    assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ref, wr_div, wr_func, wr_init}));

    // R3: every load edge returns the receiver to empty
    assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> (state == ST_EMPTY && bit_cnt == '0));
endmodule

// File: rtl/sprog_latches.sv
module sprog_latches
    import sprog_pkg::*;
#(
    parameter int REF_W     = 14,
    parameter int A_W       = 6,
    parameter int B_W       = 13,
    parameter bit CHECK_REF = 1'b1,
    parameter int PAY_W     = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAY_W-1:0] payload,
    input  logic             wr_ref,
    input  logic             wr_div,
    input  logic             wr_func,
    input  logic             wr_init,
    output logic             ref_ok,
    output logic [REF_W-1:0] ref_div,
    output logic [1:0]       backlash_sel,
    output logic             lock_prec,
    output logic [A_W-1:0]   a_cnt,
    output logic [B_W-1:0]   b_cnt,
    output logic             cp_gain,
    output func_t            func,
    output logic             init_pulse
);
    // Payload positions (payload bit 0 is word bit 2).
    localparam int ABW_LSB  = REF_W;
    localparam int TEST_LSB = ABW_LSB + 2;
    localparam int LDP_BIT  = TEST_LSB + 2;
    localparam int B_LSB    = A_W;
    localparam int GAIN_BIT = B_LSB + B_W;

    logic [REF_W-1:0] new_ref;
    logic [1:0]       new_test;

    assign new_ref  = payload[REF_W-1:0];
    assign new_test = payload[TEST_LSB+1:TEST_LSB];

    generate
        if (CHECK_REF) begin : g_ref_check
            assign ref_ok = (new_ref != '0) && (new_test == 2'b00);
        end else begin : g_ref_open
            assign ref_ok = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div      <= '0;
            backlash_sel <= '0;
            lock_prec    <= 1'b0;
        end else if (wr_ref) begin
            ref_div      <= new_ref;
            backlash_sel <= payload[ABW_LSB+1:ABW_LSB];
            lock_prec    <= payload[LDP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cnt   <= '0;
            b_cnt   <= '0;
            cp_gain <= 1'b0;
        end else if (wr_div) begin
            a_cnt   <= payload[A_W-1:0];
            b_cnt   <= payload[B_LSB+B_W-1:B_LSB];
            cp_gain <= payload[GAIN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func       <= '0;
            init_pulse <= 1'b0;
        end else begin
            init_pulse <= wr_init;
            if (wr_func || wr_init) func <= func_t'(payload[FUNC_W-1:0]);
        end
    end

    // R8: the initialization pulse lasts exactly one cycle
    assert_init_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    // R8: a function-only write never raises the initialization pulse
    assert_func_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_func |=> !init_pulse);

    // R5: the reference divide value never changes to zero
    assert_ref_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (CHECK_REF && !$stable(ref_div)) |-> (ref_div != '0));

    // R11: divider fields hold when the divider latch is not written
    assert_div_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_div |=> ($stable(a_cnt) && $stable(b_cnt) && $stable(cp_gain)));
endmodule

// File: rtl/synth_prog_reg.sv
module synth_prog_reg
    import sprog_pkg::*;
#(
    parameter int REF_W     = 14,
    parameter int A_W       = 6,
    parameter int B_W       = 13,
    parameter bit CHECK_REF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_div,
    output logic [1:0]       backlash_sel,
    output logic             lock_prec,
    output logic [A_W-1:0]   a_cnt,
    output logic [B_W-1:0]   b_cnt,
    output logic             cp_gain,
    output logic [1:0]       prescale_sel,
    output logic             pd2,
    output logic [2:0]       cur2,
    output logic [2:0]       cur1,
    output logic [3:0]       timer_sel,
    output logic             fl_mode,
    output logic             fl_en,
    output logic             cp_tristate,
    output logic             pd_pol,
    output logic [2:0]       mux_sel,
    output logic             pd1,
    output logic             cnt_hold,
    output logic             init_pulse,
    output logic             load_err
);
    localparam int WORD_W = FUNC_W + ADDR_W;
    localparam int PAY_W  = WORD_W - ADDR_W;

    logic              shift_en;
    logic              le_rise;
    logic [WORD_W-1:0] word;
    logic              ref_ok;
    logic              wr_ref, wr_div, wr_func, wr_init;
    func_t             func;

    sprog_rx #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_le   (ser_le),
        .shift_en (shift_en),
        .le_rise  (le_rise),
        .word     (word)
    );

    sprog_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .le_rise  (le_rise),
        .addr     (word[ADDR_W-1:0]),
        .ref_ok   (ref_ok),
        .wr_ref   (wr_ref),
        .wr_div   (wr_div),
        .wr_func  (wr_func),
        .wr_init  (wr_init),
        .load_err (load_err)
    );

    sprog_latches #(
        .REF_W     (REF_W),
        .A_W       (A_W),
        .B_W       (B_W),
        .CHECK_REF (CHECK_REF),
        .PAY_W     (PAY_W)
    ) u_latches (
        .clk          (clk),
        .rst_n        (rst_n),
        .payload      (word[WORD_W-1:ADDR_W]),
        .wr_ref       (wr_ref),
        .wr_div       (wr_div),
        .wr_func      (wr_func),
        .wr_init      (wr_init),
        .ref_ok       (ref_ok),
        .ref_div      (ref_div),
        .backlash_sel (backlash_sel),
        .lock_prec    (lock_prec),
        .a_cnt        (a_cnt),
        .b_cnt        (b_cnt),
        .cp_gain      (cp_gain),
        .func         (func),
        .init_pulse   (init_pulse)
    );

    assign prescale_sel = func.prescale;
    assign pd2          = func.pd2;
    assign cur2         = func.cur2;
    assign cur1         = func.cur1;
    assign timer_sel    = func.timer;
    assign fl_mode      = func.fl_mode;
    assign fl_en        = func.fl_en;
    assign cp_tristate  = func.cp_tri;
    assign pd_pol       = func.pd_pol;
    assign mux_sel      = func.mux;
    assign pd1          = func.pd1;
    assign cnt_hold     = func.cnt_hold;
endmodule

// File: tb/synth_prog_reg_tb.sv
`timescale 1ns/1ps
module synth_prog_reg_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;

    logic [13:0] ref_div;
    logic [1:0]  backlash_sel;
    logic        lock_prec;
    logic [5:0]  a_cnt;
    logic [12:0] b_cnt;
    logic        cp_gain;
    logic [1:0]  prescale_sel;
    logic        pd2;
    logic [2:0]  cur2, cur1;
    logic [3:0]  timer_sel;
    logic        fl_mode, fl_en, cp_tristate, pd_pol;
    logic [2:0]  mux_sel;
    logic        pd1, cnt_hold, init_pulse, load_err;

    int checks = 0;
    int errors = 0;
    logic err_s, ip_s, ip_next;

    always #4 clk = ~clk;

    synth_prog_reg u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_div(ref_div), .backlash_sel(backlash_sel), .lock_prec(lock_prec),
        .a_cnt(a_cnt), .b_cnt(b_cnt), .cp_gain(cp_gain),
        .prescale_sel(prescale_sel), .pd2(pd2), .cur2(cur2), .cur1(cur1),
        .timer_sel(timer_sel), .fl_mode(fl_mode), .fl_en(fl_en),
        .cp_tristate(cp_tristate), .pd_pol(pd_pol), .mux_sel(mux_sel),
        .pd1(pd1), .cnt_hold(cnt_hold), .init_pulse(init_pulse), .load_err(load_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Shift v[n-1:0] MSB first, one serial clock high per bit.
    task automatic send_bits(input logic [47:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_clk = 1'b0; ser_data = v[i];
            @(negedge clk); ser_clk = 1'b1;
        end
        @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic pulse_le();
        @(negedge clk); ser_le = 1'b1;
        @(negedge clk); err_s = load_err; ip_s = init_pulse; ser_le = 1'b0;
        @(negedge clk); ip_next = init_pulse;
    endtask

    function automatic logic [23:0] ref_word(input logic [13:0] d, input logic [1:0] abw,
                                             input logic [1:0] tst, input logic ldp);
        return {3'b000, ldp, tst, abw, d, 2'b00};
    endfunction

    function automatic logic [23:0] div_word(input logic [5:0] a, input logic [12:0] b, input logic g);
        return {2'b00, g, b, a, 2'b01};
    endfunction

    task automatic t_reset();
        chk("R1", "ref_div", 32'(ref_div), 0);
        chk("R1", "a_cnt", 32'(a_cnt), 0);
        chk("R1", "b_cnt", 32'(b_cnt), 0);
        chk("R1", "func fields", 32'({prescale_sel, pd2, cur2, cur1, timer_sel, fl_mode, fl_en,
                                       cp_tristate, pd_pol, mux_sel, pd1, cnt_hold}), 0);
        chk("R1", "pulses", 32'({init_pulse, load_err}), 0);
    endtask

    task automatic t_ref();
        send_bits(48'(ref_word(14'd1, 2'b10, 2'b00, 1'b1)), 24);
        pulse_le();
        chk("R3", "load_err", 32'(err_s), 0);
        chk("R2", "ref_div msb-first", 32'(ref_div), 1);
        chk("R4", "backlash_sel", 32'(backlash_sel), 2);
        chk("R4", "lock_prec", 32'(lock_prec), 1);
        send_bits(48'(ref_word(14'h3FFF, 2'b01, 2'b00, 1'b0)), 24);
        pulse_le();
        chk("R4", "ref_div max", 32'(ref_div), 32'h3FFF);
        chk("R4", "lock_prec clear", 32'(lock_prec), 0);
    endtask

    task automatic t_div();
        send_bits(48'(div_word(6'd63, 13'd8191, 1'b1)), 24);
        pulse_le();
        chk("R6", "a_cnt", 32'(a_cnt), 63);
        chk("R6", "b_cnt", 32'(b_cnt), 8191);
        chk("R6", "cp_gain", 32'(cp_gain), 1);
        chk("R11", "ref_div kept", 32'(ref_div), 32'h3FFF);
        send_bits(48'(div_word(6'd5, 13'd300, 1'b0)), 24);
        pulse_le();
        chk("R6", "a/b/gain second", 32'({a_cnt, b_cnt, cp_gain}), 32'({6'd5, 13'd300, 1'b0}));
    endtask

    task automatic t_func();
        logic [23:0] w;
        w = {2'b10, 1'b1, 3'b101, 3'b011, 4'b1001, 1'b1, 1'b0, 1'b1, 1'b0, 3'b110, 1'b1, 1'b0, 2'b10};
        send_bits(48'(w), 24);
        pulse_le();
        chk("R7", "func fields", 32'({prescale_sel, pd2, cur2, cur1, timer_sel, fl_mode, fl_en,
                                      cp_tristate, pd_pol, mux_sel, pd1, cnt_hold}), 32'(w[23:2]));
        chk("R8", "no init pulse on function", 32'({ip_s, ip_next}), 0);
        chk("R11", "divider kept", 32'({a_cnt, b_cnt}), 32'({6'd5, 13'd300}));
    endtask

    task automatic t_init();
        logic [23:0] w;
        w = {2'b01, 1'b0, 3'b010, 3'b110, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 1'b0, 1'b1, 2'b11};
        send_bits(48'(w), 24);
        pulse_le();
        chk("R8", "init fields", 32'({prescale_sel, pd2, cur2, cur1, timer_sel, fl_mode, fl_en,
                                      cp_tristate, pd_pol, mux_sel, pd1, cnt_hold}), 32'(w[23:2]));
        chk("R8", "init pulse high", 32'(ip_s), 1);
        chk("R8", "init pulse one cycle", 32'(ip_next), 0);
    endtask

    task automatic t_short();
        send_bits(48'(div_word(6'd9, 13'd77, 1'b1)), 23);
        pulse_le();
        chk("R9", "short load_err", 32'(err_s), 1);
        chk("R9", "short ignored", 32'({a_cnt, b_cnt, cp_gain}), 32'({6'd5, 13'd300, 1'b0}));
        chk("R9", "load_err one cycle", 32'(load_err), 0);
        pulse_le();
        chk("R9", "count restarts", 32'(err_s), 1);
    endtask

    task automatic t_bad_ref();
        send_bits(48'(ref_word(14'd0, 2'b11, 2'b00, 1'b1)), 24);
        pulse_le();
        chk("R5", "zero divide refused", 32'(err_s), 1);
        chk("R5", "ref fields kept", 32'({ref_div, backlash_sel, lock_prec}), 32'({14'h3FFF, 2'b01, 1'b0}));
        send_bits(48'(ref_word(14'd20, 2'b11, 2'b01, 1'b1)), 24);
        pulse_le();
        chk("R5", "test bits refused", 32'(err_s), 1);
        chk("R5", "ref_div kept", 32'(ref_div), 32'h3FFF);
    endtask

    task automatic t_long();
        logic [47:0] v;
        v = {24'h0, 6'b111111, div_word(6'd33, 13'd4097, 1'b0)};
        send_bits(v, 30);
        pulse_le();
        chk("R10", "long load accepted", 32'(err_s), 0);
        chk("R10", "last 24 bits", 32'({a_cnt, b_cnt, cp_gain}), 32'({6'd33, 13'd4097, 1'b0}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ref();
        t_div();
        t_func();
        t_init();
        t_short();
        t_bad_ref();
        t_long();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule